// File: doc/BRIEF.md
# Packet Ring Write Channel

This block moves a byte stream made of fixed-length transport packets into a circular region of host memory. Software describes the region through a start address and a packed geometry word: bytes per packet, packets per block and blocks per ring. Each byte that the channel accepts becomes a single-byte memory write request at the current head address. The head then advances and returns to the start address once it has covered the whole ring.

A control/status word has two write ports. One sets bits and the other clears them. Its bits are a run enable, an error flag and an interrupt-pending flag. The interrupt flag rises whenever a block fills. It also rises when a programmable idle timeout expires while a partially filled block is outstanding, so that a slow stream still reaches software. The timeout counts clock cycles, which are 8 ns units at the intended clock. Free-running counters record presented, accepted, idle-dropped and overrun bytes, and the number of timeout flushes. Software reads the head address to learn how far the data has advanced.

Top module: `pkt_ring_dma`

## Requirements
- R1: After reset the status word reads 0, the geometry register reads 0x0880_00BC (8 blocks in bits [31:24], 128 packets in bits [23:16], 188 bytes in bits [7:0]), the timeout register reads 375000000 and the head reads 0.
- R2: Register index 0 is the set port and index 1 is the clear port. Writing a 1 in bit 0 (run), bit 1 (error) or bit 9 (interrupt pending) sets that bit through port 0 and clears it through port 1. Reading either index returns the status word.
- R3: The start address register (index 2) keeps only bits [29:0] of the written value, and the upper address (index 3) reads back as written.
- R4: Each accepted byte appears on the write request with an address equal to the head at the time it was accepted, and the head (index 6) then advances by one.
- R5: The ring size is the product of the three geometry fields. After a byte at offset ring size minus one, the head returns to the start address.
- R6: The byte that completes a block (packet bytes times packets per block since the last boundary) sets the interrupt-pending bit.
- R7: When a block is partly filled and no byte is accepted for the number of cycles held in the timeout register (index 5), the interrupt-pending bit is set and the flush counter (index 11) increments. This happens once per idle gap, and a value of 0 disables the timeout.
- R8: While run is 0, input bytes are not written and the head holds. Each such byte increments the idle-drop counter (index 10).
- R9: Setting run from 0 reloads the head to the start address and empties the partial block.
- R10: A byte that arrives while the write request is held without acceptance is dropped. It increments the overrun counter (index 12) and sets the error bit, and the held request keeps its address and data.
- R11: Index 8 counts every presented byte and index 9 counts every accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| wr_valid | output | 1 | Memory write request pending |
| wr_addr | output | 32 | Byte address of the write |
| wr_data | output | 8 | Byte to write |
| wr_ready | input | 1 | Memory side takes the request |
| irq | output | 1 | Interrupt-pending flag |

## Verification
The bench uses a small geometry of 24-byte rings made of 8-byte blocks. It feeds runs of bytes whose sums straddle block edges and the ring end, so a design that computes the ring size from the wrong fields, or that wraps one byte late, shows the wrong head or the wrong write address. It stops and restarts the channel to catch a head that keeps moving while stopped, or that fails to return to the start address and keeps a stale partial-block count. With the memory side stalled it presents extra bytes, which exposes a held request that gets overwritten or an overrun that is not counted. The idle-timeout test checks that the flag stays low early in the gap, rises after the programmed count, and does not fire a second time without new data.

// File: rtl/pkt_ring_pkg.sv
package pkt_ring_pkg;

    typedef enum logic [3:0] {
        RG_SET       = 4'd0,
        RG_CLR       = 4'd1,
        RG_START_LO  = 4'd2,
        RG_START_HI  = 4'd3,
        RG_SIZE      = 4'd4,
        RG_TMO       = 4'd5,
        RG_HEAD_LO   = 4'd6,
        RG_HEAD_HI   = 4'd7,
        RG_CNT_BASE  = 4'd8
    } reg_idx_e;

    localparam int NUM_CNT = 5;
    localparam int RUN_BIT = 0;
    localparam int ERR_BIT = 1;
    localparam int IRQ_BIT = 9;
    localparam int OFF_W   = 24;
    localparam int BLK_W   = 16;

    typedef struct packed {
        logic [7:0] blocks;
        logic [7:0] pkts;
        logic [7:0] spare;
        logic [7:0] pkt_bytes;
    } geom_t;

    typedef struct packed {
        logic run;
        logic err;
        logic irq;
    } ctrl_t;

    typedef struct packed {
        logic presented;
        logic accept;
        logic drop_idle;
        logic drop_full;
        logic blk_done;
        logic flush;
    } evt_t;

    function automatic logic [31:0] pack_geom(input int blocks, input int pkts, input int bytes);
        geom_t g;
        g.blocks    = 8'(blocks);
        g.pkts      = 8'(pkts);
        g.spare     = 8'd0;
        g.pkt_bytes = 8'(bytes);
        return g;
    endfunction

    function automatic logic [BLK_W-1:0] block_len(input geom_t g);
        return BLK_W'(g.pkt_bytes) * BLK_W'(g.pkts);
    endfunction

    function automatic logic [OFF_W-1:0] ring_len(input geom_t g);
        return OFF_W'(block_len(g)) * OFF_W'(g.blocks);
    endfunction

endpackage

// File: rtl/pkt_ring_regs.sv
module pkt_ring_regs
    import pkt_ring_pkg::*;
#(
    parameter logic [31:0] SIZE_RST = 32'h0880_00BC,
    parameter logic [31:0] TMO_RST  = 32'd375000000,
    parameter int          CNT_W    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [3:0]       addr,
    input  logic [31:0]      wdata,
    input  evt_t             evt,
    input  logic [31:0]      head_addr,
    output logic [31:0]      rdata,
    output logic             run,
    output logic             run_rise,
    output logic [31:0]      start,
    output logic [31:0]      timeout,
    output logic [BLK_W-1:0] blk_len,
    output logic [OFF_W-1:0] ring_size,
    output logic             irq
);
    ctrl_t       ctrl_q, ctrl_d;
    logic [31:0] start_hi_q;
    geom_t       geom_q;
    logic [31:0] tmo_q;
    logic        set_w, clr_w;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0]   cnt_q [NUM_CNT];

    assign set_w = we && (addr == RG_SET);
    assign clr_w = we && (addr == RG_CLR);

    always_comb begin
        ctrl_d = ctrl_q;
        if (set_w) begin
            if (wdata[RUN_BIT]) ctrl_d.run = 1'b1;
            if (wdata[ERR_BIT]) ctrl_d.err = 1'b1;
            if (wdata[IRQ_BIT]) ctrl_d.irq = 1'b1;
        end
        if (clr_w) begin
            if (wdata[RUN_BIT]) ctrl_d.run = 1'b0;
            if (wdata[ERR_BIT]) ctrl_d.err = 1'b0;
            if (wdata[IRQ_BIT]) ctrl_d.irq = 1'b0;
        end
        // hardware events take precedence over a software clear
        if (evt.drop_full)            ctrl_d.err = 1'b1;
        if (evt.blk_done || evt.flush) ctrl_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            start_hi_q <= '0;
            geom_q     <= SIZE_RST;
            tmo_q      <= TMO_RST;
            start      <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (we) begin
                case (addr)
                    RG_START_LO: start      <= {2'b00, wdata[29:0]};
                    RG_START_HI: start_hi_q <= wdata;
                    RG_SIZE:     geom_q     <= wdata;
                    RG_TMO:      tmo_q      <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign cnt_inc = {evt.drop_full, evt.flush, evt.drop_idle, evt.accept, evt.presented};

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)             cnt_q[k] <= '0;
            else if (cnt_inc[k]) cnt_q[k] <= cnt_q[k] + 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RG_SET, RG_CLR: begin
                rdata[RUN_BIT] = ctrl_q.run;
                rdata[ERR_BIT] = ctrl_q.err;
                rdata[IRQ_BIT] = ctrl_q.irq;
            end
            RG_START_LO: rdata = start;
            RG_START_HI: rdata = start_hi_q;
            RG_SIZE:     rdata = geom_q;
            RG_TMO:      rdata = tmo_q;
            RG_HEAD_LO:  rdata = head_addr;
            RG_HEAD_HI:  rdata = start_hi_q;
            default: begin
                if (addr >= RG_CNT_BASE && addr < 4'(RG_CNT_BASE + NUM_CNT))
                    rdata = 32'(cnt_q[3'(addr - RG_CNT_BASE)]);
            end
        endcase
    end

    assign run       = ctrl_q.run;
    assign run_rise  = set_w && wdata[RUN_BIT] && !ctrl_q.run;
    assign timeout   = tmo_q;
    assign blk_len   = block_len(geom_q);
    assign ring_size = ring_len(geom_q);
    assign irq       = ctrl_q.irq;

    a_r6_block_irq: assert property (@(posedge clk) disable iff (rst)
        evt.blk_done |=> irq);
    a_r7_flush_irq: assert property (@(posedge clk) disable iff (rst)
        evt.flush |=> irq);
    a_r10_err_flag: assert property (@(posedge clk) disable iff (rst)
        evt.drop_full |=> ctrl_q.err);
    a_r2_irq_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_w && wdata[IRQ_BIT] && !evt.blk_done && !evt.flush) |=> !irq);

endmodule

// File: rtl/pkt_ring_addr.sv
module pkt_ring_addr
    import pkt_ring_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             run_rise,
    input  logic [31:0]      start,
    input  logic [BLK_W-1:0] blk_len,
    input  logic [OFF_W-1:0] ring_size,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             wr_ready,
    output logic             wr_valid,
    output logic [31:0]      wr_addr,
    output logic [7:0]       wr_data,
    output logic [31:0]      head_addr,
    output logic             blk_pend,
    output logic             accept,
    output logic             drop_full,
    output logic             drop_idle,
    output logic             blk_done
);
    logic [OFF_W-1:0] head_off, off_nxt;
    logic [BLK_W-1:0] fill;
    logic             slot_free, blk_last;

    assign slot_free = !wr_valid || wr_ready;
    assign accept    = in_valid && run && slot_free;
    assign drop_full = in_valid && run && !slot_free;
    assign drop_idle = in_valid && !run;
    assign blk_last  = (fill + 1'b1) >= blk_len;
    assign blk_done  = accept && blk_last;
    assign off_nxt   = ((head_off + 1'b1) >= ring_size) ? '0 : head_off + 1'b1;
    assign head_addr = start + 32'(head_off);
    assign blk_pend  = (fill != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_off <= '0;
            fill     <= '0;
        end else if (run_rise) begin
            head_off <= '0;
            fill     <= '0;
        end else if (accept) begin
            head_off <= off_nxt;
            fill     <= blk_last ? '0 : fill + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (accept) begin
            wr_valid <= 1'b1;
            wr_addr  <= head_addr;
            wr_data  <= in_data;
        end else if (wr_ready) begin
            wr_valid <= 1'b0;
        end
    end

    a_r10_slot_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
    a_r8_head_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !run_rise) |=> $stable(head_off));
    a_r9_reload: assert property (@(posedge clk) disable iff (rst)
        run_rise |=> (head_off == '0 && fill == '0));
    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (accept && !run_rise && (head_off + 1'b1 == ring_size)) |=> (head_off == '0));
    a_r4_write_addr: assert property (@(posedge clk) disable iff (rst)
        accept |=> (wr_valid && wr_addr == $past(head_addr)));

endmodule

// File: rtl/pkt_ring_timer.sv
module pkt_ring_timer (
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        accept,
    input  logic        pend,
    input  logic [31:0] timeout,
    output logic        flush
);
    logic [31:0] cnt;
    logic        armed;

    assign flush = run && pend && armed && !accept && (timeout != '0)
                   && ((cnt + 1'b1) >= timeout);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (accept) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (flush) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (run && pend && armed) begin
            cnt   <= cnt + 1'b1;
        end
    end

    a_r7_single_flush: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush);
    a_r7_needs_gap: assert property (@(posedge clk) disable iff (rst)
        accept |=> !flush || (timeout <= 32'd1));

endmodule

// File: rtl/pkt_ring_dma.sv
module pkt_ring_dma
    import pkt_ring_pkg::*;
#(
    parameter int DEF_PKT_BYTES    = 188,
    parameter int DEF_PKTS_PER_BLK = 128,
    parameter int DEF_BLOCKS       = 8,
    parameter int DEF_TIMEOUT      = 375000000,
    parameter int CNT_W            = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        wr_valid,
    output logic [31:0] wr_addr,
    output logic [7:0]  wr_data,
    input  logic        wr_ready,
    output logic        irq
);
    localparam logic [31:0] SIZE_RST = pack_geom(DEF_BLOCKS, DEF_PKTS_PER_BLK, DEF_PKT_BYTES);
    localparam logic [31:0] TMO_RST  = 32'(DEF_TIMEOUT);

    evt_t             evt;
    logic             run, run_rise, blk_pend;
    logic [31:0]      start, timeout, head_addr;
    logic [BLK_W-1:0] blk_len;
    logic [OFF_W-1:0] ring_size;
    logic             accept, drop_full, drop_idle, blk_done, flush;

    always_comb begin
        evt.presented = in_valid;
        evt.accept    = accept;
        evt.drop_idle = drop_idle;
        evt.drop_full = drop_full;
        evt.blk_done  = blk_done;
        evt.flush     = flush;
    end

    pkt_ring_regs #(
        .SIZE_RST (SIZE_RST),
        .TMO_RST  (TMO_RST),
        .CNT_W    (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .evt       (evt),
        .head_addr (head_addr),
        .rdata     (reg_rdata),
        .run       (run),
        .run_rise  (run_rise),
        .start     (start),
        .timeout   (timeout),
        .blk_len   (blk_len),
        .ring_size (ring_size),
        .irq       (irq)
    );

    pkt_ring_addr u_addr (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .run_rise  (run_rise),
        .start     (start),
        .blk_len   (blk_len),
        .ring_size (ring_size),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .wr_ready  (wr_ready),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .head_addr (head_addr),
        .blk_pend  (blk_pend),
        .accept    (accept),
        .drop_full (drop_full),
        .drop_idle (drop_idle),
        .blk_done  (blk_done)
    );

    pkt_ring_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .accept  (accept),
        .pend    (blk_pend),
        .timeout (timeout),
        .flush   (flush)
    );

endmodule

// File: tb/test_pkt_ring_dma.sv
module test_pkt_ring_dma;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_ready = 1'b1;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    logic [31:0] last_addr;
    logic [31:0] rv;

    localparam int VEC_N = 5;
    localparam int          V_BYTES [VEC_N] = '{3, 5, 7, 9, 1};
    localparam logic [31:0] V_HEAD  [VEC_N] = '{32'h103, 32'h108, 32'h10F, 32'h100, 32'h101};
    localparam logic [31:0] V_LAST  [VEC_N] = '{32'h102, 32'h107, 32'h10E, 32'h117, 32'h100};
    localparam logic        V_IRQ   [VEC_N] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    always #10 clk = ~clk;

    pkt_ring_dma i_pkt_ring_dma (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_data(in_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = 8'(i + 8'h40);
            @(negedge clk);
            last_addr = wr_addr;
        end
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values
        rd_reg(4'd0, rv); check("R1 status", rv, 32'h0);
        rd_reg(4'd4, rv); check("R1 size", rv, 32'h0880_00BC);
        rd_reg(4'd5, rv); check("R1 timeout", rv, 32'd375000000);
        rd_reg(4'd6, rv); check("R1 head", rv, 32'h0);

        // R3: start address masking
        wr_reg(4'd2, 32'hFFFF_FFFF);
        rd_reg(4'd2, rv); check("R3 start mask", rv, 32'h3FFF_FFFF);
        wr_reg(4'd3, 32'h0000_0000);
        rd_reg(4'd3, rv); check("R3 start hi", rv, 32'h0);
        wr_reg(4'd2, 32'h100);
        wr_reg(4'd4, 32'h0302_0004);   // 3 blocks, 2 packets, 4 bytes

        // R2, R9: set/clear ports, run start reloads head
        wr_reg(4'd0, 32'h1);
        rd_reg(4'd0, rv); check("R2 set run", rv, 32'h1);
        rd_reg(4'd1, rv); check("R2 read via clear port", rv, 32'h1);
        wr_reg(4'd0, 32'h2);
        rd_reg(4'd0, rv); check("R2 set err", rv, 32'h3);
        wr_reg(4'd1, 32'h2);
        rd_reg(4'd0, rv); check("R2 clear err", rv, 32'h1);
        rd_reg(4'd6, rv); check("R9 head at start", rv, 32'h100);

        // R4, R5, R6: vector table
        for (int v = 0; v < VEC_N; v++) begin
            push(V_BYTES[v]);
            check($sformatf("R4 last write addr vec%0d", v), last_addr, V_LAST[v]);
            rd_reg(4'd6, rv);
            check($sformatf("R5 head vec%0d", v), rv, V_HEAD[v]);
            check($sformatf("R6 irq vec%0d", v), 32'(irq), 32'(V_IRQ[v]));
            wr_reg(4'd1, 32'h200);
        end

        // R8: stopped channel ignores input, holds head
        wr_reg(4'd1, 32'h1);
        idle(2);
        push(4);
        idle(1);
        check("R8 no write while stopped", 32'(wr_valid), 32'h0);
        rd_reg(4'd6, rv); check("R8 head held", rv, 32'h101);
        rd_reg(4'd10, rv); check("R8 idle drops", rv, 32'd4);

        // R9: restart reloads head and empties partial block
        wr_reg(4'd0, 32'h1);
        rd_reg(4'd6, rv); check("R9 head reload", rv, 32'h100);
        push(7);
        check("R9 no irq before block end", 32'(irq), 32'h0);
        push(1);
        check("R9 irq on full block", 32'(irq), 32'h1);
        wr_reg(4'd1, 32'h200);

        // R10: stalled write slot
        wr_ready = 1'b0;
        push(3);
        check("R10 slot valid", 32'(wr_valid), 32'h1);
        check("R10 slot addr held", wr_addr, 32'h108);
        check("R10 slot data held", 32'(wr_data), 32'h40);
        rd_reg(4'd12, rv); check("R10 overrun count", rv, 32'd2);
        rd_reg(4'd0, rv); check("R10 err set", rv & 32'h2, 32'h2);
        rd_reg(4'd6, rv); check("R10 head", rv, 32'h109);
        wr_ready = 1'b1;
        idle(1);
        check("R10 slot drained", 32'(wr_valid), 32'h0);

        // R7: idle timeout with a partial block
        wr_reg(4'd5, 32'd20);
        idle(30);
        rd_reg(4'd11, rv); check("R7 first flush", rv, 32'd1);
        wr_reg(4'd1, 32'h200);
        push(1);
        idle(10);
        check("R7 no flush early", 32'(irq), 32'h0);
        idle(15);
        check("R7 flush after gap", 32'(irq), 32'h1);
        rd_reg(4'd11, rv); check("R7 flush count", rv, 32'd2);
        wr_reg(4'd1, 32'h200);
        idle(60);
        check("R7 single flush per gap", 32'(irq), 32'h0);

        // R11: statistics
        rd_reg(4'd8, rv); check("R11 presented", rv, 32'd41);
        rd_reg(4'd9, rv); check("R11 accepted", rv, 32'd35);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule